// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block sits on the host side of a byte-wide parallel flash bus and writes a run of bytes into the part, starting at address zero. When `start` is sampled in idle, it records the byte count and turns on the programming-voltage enable. It then waits a fixed ramp interval and handles the bytes one after another. For each byte it takes the value from a request/valid source and issues a program-setup command. It then writes the address and data, waits out the program pulse, issues the verify command, waits for the margin settle time, and reads the byte back for comparison.

A byte that reads back wrong gets another pulse. The pulse limit is configurable. If the byte still reads wrong after the last allowed pulse, the run stops. Passing and failing runs end the same way: the block writes the read command, drops the programming voltage, waits the ramp interval, and then reports the result. A failing run also reports the address that failed. All waits are counted in clock cycles set by parameters. Address and data are set up one cycle before write-enable falls and held one cycle after it rises.

Top module: `flash_prog_seq`

## Requirements
- R1: In reset and after it, the chip-enable, output-enable and write-enable lines are high, data drive and the programming-voltage enable are off, and `busy`, `done` and `src_req` are low.
- R2: A start with a non-zero count raises `hv_en`, holds it for at least RAMP_CYC cycles before the first chip-enable low, and programs addresses ascending from 0.
- R3: Every bus write holds chip-enable low with address and data driven one cycle before write-enable falls. Write-enable stays low for exactly WE_CYC cycles and is followed by one hold cycle. `hv_en` is high throughout.
- R4: Each byte is fetched once through `src_req`/`src_valid`, and the sequencer waits in the fetch state while `src_valid` is low. A byte is written as a 0x40 command followed by a write of the fetched value to the byte's address.
- R5: After the data write, write-enable stays high for exactly PROG_CYC+2 sampled cycles before the 0xC0 verify command's write-enable falls.
- R6: After the 0xC0 write, PROG verify settle takes VERIFY_CYC cycles: output-enable falls VERIFY_CYC+1 cycles after write-enable rises and stays low for READ_CYC cycles. The value read in the last of these cycles is compared with the fetched byte. Write-enable stays high and data drive stays off while output-enable is low.
- R7: A mismatch repeats the 0x40/data/0xC0/read sequence on the same byte. A match moves to the next byte. A byte gets at most MAX_PULSES pulses, and a byte that matches after k pulses gets exactly k.
- R8: After the last byte matches, the block writes 0x00 and drops `hv_en`. After exactly RAMP_CYC cycles it pulses `done` for one cycle with `pass`=1 and `fail`=0.
- R9: If a byte still mismatches after MAX_PULSES pulses, the block writes 0x00 and drops `hv_en`, then pulses `done` with `fail`=1, `pass`=0 and `fail_addr` set to that byte's address. Later bytes are neither fetched nor written.
- R10: A start with `byte_count`=0 gives `done` with `pass`=1 in the following cycle. There is no bus cycle, and `hv_en` stays low.
- R11: `start` is ignored while `busy` is high. The run keeps its original count, and only one `done` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (sampled in idle) |
| byte_count | input | ADDR_W+1 | Number of bytes to program |
| src_req | output | 1 | Sequencer wants the next data byte |
| src_valid | input | 1 | Source has a byte on `src_data` |
| src_data | input | DW | Byte to program |
| ce_n | output | 1 | Flash chip enable, active low |
| oe_n | output | 1 | Flash output enable, active low |
| we_n | output | 1 | Flash write enable, active low |
| addr_o | output | ADDR_W | Flash address |
| dq_o | output | DW | Data driven to the flash |
| dq_oe | output | 1 | Drive enable for `dq_o` |
| dq_i | input | DW | Data read from the flash |
| hv_en | output | 1 | Programming-voltage enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run succeeded |
| fail | output | 1 | Last run hit the pulse limit |
| fail_addr | output | ADDR_W | Address of the byte that failed |

## Verification
The bench builds the block with ADDR_W=6, RAMP_CYC=8, PROG_CYC=12, VERIFY_CYC=5, WE_CYC=3 and READ_CYC=2, and keeps MAX_PULSES at 25. The short waits keep every run to a few thousand cycles, so a full 64-byte span ending at the top address fits in the run. Keeping the default pulse limit puts the boundary case inside the table: a byte that needs exactly 25 pulses passes, and one that needs 26 fails. A flash model counts pulses per address, programs a byte only after its required number of pulses, and measures the cycle gaps between bus events.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ADDR_W     = 17,
  parameter int DW         = 8,
  parameter int MAX_PULSES = 25,
  parameter int RAMP_CYC   = 250,
  parameter int PROG_CYC   = 2500,
  parameter int VERIFY_CYC = 1500,
  parameter int WE_CYC     = 15,
  parameter int READ_CYC   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W:0]   byte_count,
  output logic              src_req,
  input  logic              src_valid,
  input  logic [DW-1:0]     src_data,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe,
  input  logic [DW-1:0]     dq_i,
  output logic              hv_en,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int CW   = ADDR_W + 1;
  localparam int PW   = $clog2(MAX_PULSES + 1);
  localparam int T1   = (RAMP_CYC > PROG_CYC) ? RAMP_CYC : PROG_CYC;
  localparam int T2   = (T1 > VERIFY_CYC) ? T1 : VERIFY_CYC;
  localparam int T3   = (T2 > WE_CYC) ? T2 : WE_CYC;
  localparam int TMAX = (T3 > READ_CYC) ? T3 : READ_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [DW-1:0] CMD_SETUP  = DW'(8'h40);
  localparam logic [DW-1:0] CMD_VERIFY = DW'(8'hC0);
  localparam logic [DW-1:0] CMD_READ   = DW'(8'h00);

  typedef enum logic [3:0] {
    S_IDLE, S_RAMPUP, S_FETCH, S_WSET, S_WLOW, S_WHOLD,
    S_PROG, S_VSET, S_READ, S_RAMPDN, S_FIN
  } st_t;
  typedef enum logic [1:0] {K_SETUP, K_DATA, K_VERIFY, K_RDCMD} wk_t;

  st_t st, st_d;
  wk_t wk, wk_d;
  logic [TW-1:0]     tmr, ld;
  logic [PW-1:0]     pls;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     cnt_q;
  logic [DW-1:0]     data_q;
  logic              bad;

  wire t0      = (tmr == '0);
  wire hit     = (dq_i == data_q);
  wire last    = (CW'(addr_q) + CW'(1)) == cnt_q;
  wire give_up = (pls == PW'(MAX_PULSES));

  assign src_req = (st == S_FETCH);
  assign busy    = (st != S_IDLE);
  assign addr_o  = addr_q;

  always_comb begin
    st_d = st;
    wk_d = wk;
    case (st)
      S_IDLE:   if (start) st_d = (byte_count == '0) ? S_FIN : S_RAMPUP;
      S_RAMPUP: if (t0) st_d = S_FETCH;
      S_FETCH:  if (src_valid) begin st_d = S_WSET; wk_d = K_SETUP; end
      S_WSET:   st_d = S_WLOW;
      S_WLOW:   if (t0) st_d = S_WHOLD;
      S_WHOLD:
        case (wk)
          K_SETUP:  begin st_d = S_WSET; wk_d = K_DATA; end
          K_DATA:   st_d = S_PROG;
          K_VERIFY: st_d = S_VSET;
          default:  st_d = S_RAMPDN;
        endcase
      S_PROG:   if (t0) begin st_d = S_WSET; wk_d = K_VERIFY; end
      S_VSET:   if (t0) st_d = S_READ;
      S_READ:
        if (t0) begin
          if (hit && !last) st_d = S_FETCH;
          else begin
            st_d = S_WSET;
            wk_d = (hit || give_up) ? K_RDCMD : K_SETUP;
          end
        end
      S_RAMPDN: if (t0) st_d = S_FIN;
      default:  st_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (st_d)
      S_RAMPUP, S_RAMPDN: ld = TW'(RAMP_CYC - 1);
      S_WLOW:             ld = TW'(WE_CYC - 1);
      S_PROG:             ld = TW'(PROG_CYC - 1);
      S_VSET:             ld = TW'(VERIFY_CYC - 1);
      S_READ:             ld = TW'(READ_CYC - 1);
      default:            ld = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wk <= K_SETUP; tmr <= '0; pls <= '0;
      addr_q <= '0; cnt_q <= '0; data_q <= '0; bad <= 1'b0;
      ce_n <= 1'b1; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0; dq_o <= '0;
      hv_en <= 1'b0; done <= 1'b0; pass <= 1'b0; fail <= 1'b0; fail_addr <= '0;
    end else begin
      st  <= st_d;
      wk  <= wk_d;
      tmr <= (st_d != st) ? ld : (t0 ? tmr : tmr - TW'(1));
      ce_n  <= !(st_d inside {S_WSET, S_WLOW, S_WHOLD, S_READ});
      we_n  <= (st_d != S_WLOW);
      oe_n  <= (st_d != S_READ);
      dq_oe <= (st_d inside {S_WSET, S_WLOW, S_WHOLD});
      if (st_d == S_WSET && st != S_WSET)
        case (wk_d)
          K_SETUP:  dq_o <= CMD_SETUP;
          K_DATA:   dq_o <= data_q;
          K_VERIFY: dq_o <= CMD_VERIFY;
          default:  dq_o <= CMD_READ;
        endcase
      if (st == S_IDLE && start) begin
        cnt_q <= byte_count; addr_q <= '0; bad <= 1'b0;
        pass <= 1'b0; fail <= 1'b0; fail_addr <= '0;
        hv_en <= (byte_count != '0);
      end
      if (st == S_FETCH && src_valid) begin
        data_q <= src_data;
        pls    <= PW'(1);
      end
      if (st == S_READ && t0) begin
        if (!hit) begin
          if (give_up) begin bad <= 1'b1; fail_addr <= addr_q; end
          else pls <= pls + PW'(1);
        end else if (!last) addr_q <= addr_q + ADDR_W'(1);
      end
      if (st_d == S_RAMPDN) hv_en <= 1'b0;
      done <= (st_d == S_FIN);
      if (st_d == S_FIN) begin
        pass <= (st == S_IDLE) | !bad;
        fail <= (st != S_IDLE) & bad;
      end
    end
  end

  assert_we_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n && dq_oe && hv_en);
  assert_bus_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> $stable(addr_o) && $stable(dq_o));
  assert_fetch_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_req && !src_valid |=> src_req);
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> we_n && !dq_oe);
  assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pls <= PW'(MAX_PULSES));
  assert_hv_off_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hv_en && (pass != fail));
  assert_fail_after_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done && !hv_en);
  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && byte_count == '0) |=> done && pass && !hv_en && ce_n);
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cnt_q));
endmodule

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;
  localparam int AW = 6, DW = 8, NP = 25, RC = 8, PC = 12, VC = 5, WC = 3, RDC = 2;
  localparam int DEPTH = 1 << AW;
  localparam int NROW = 7;
  // cnt, seed, need, hard_pos, hard_need, src_delay, exp_pass, exp_fail_addr
  localparam int TBL[NROW][8] = '{
    '{8,  'h5A, 1, 0,  1,  0, 1, 0},
    '{6,  'h33, 3, 2,  7,  2, 1, 0},
    '{5,  'h0F, 1, 4,  25, 1, 1, 0},
    '{7,  'hC4, 2, 3,  26, 0, 0, 3},
    '{1,  'hA5, 1, 0,  26, 3, 0, 0},
    '{64, 'h71, 1, 63, 2,  1, 1, 0},
    '{3,  'h00, 1, 1,  1,  0, 1, 0}
  };

  logic clk = 0, rst_n = 0, start = 0, src_valid = 0;
  logic [AW:0] byte_count = '0;
  logic [DW-1:0] src_data = '0;
  logic src_req, ce_n, oe_n, we_n, dq_oe, hv_en, busy, done, pass, fail;
  logic [AW-1:0] addr_o, fail_addr;
  logic [DW-1:0] dq_o, dq_i;

  flash_prog_seq #(.ADDR_W(AW), .DW(DW), .MAX_PULSES(NP), .RAMP_CYC(RC),
    .PROG_CYC(PC), .VERIFY_CYC(VC), .WE_CYC(WC), .READ_CYC(RDC)) u_flash_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .src_req(src_req), .src_valid(src_valid), .src_data(src_data),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr_o(addr_o), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i), .hv_en(hv_en), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .fail_addr(fail_addr));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] mem [DEPTH];
  int pcnt [DEPTH];
  int need [DEPTH];
  int mode = 0, last_kind = 0, hi_cnt = 0, lo_cnt = 0, low_w = 0, rd_w = 0, hv_cnt = 0;
  int done_cnt = 0, hs_cnt = 0, dly = 0, widx = 0, wcnt = 0;
  bit first_ce = 0, dropped = 0, took = 0;
  logic we_p = 1, oe_p = 1, hv_p = 0;
  logic [AW-1:0] la = '0;
  logic [7:0] seed = '0;

  assign dq_i = (!ce_n && !oe_n) ? mem[addr_o] : 8'hE7;

  function automatic logic [7:0] pat(logic [7:0] s, int a);
    return (s ^ 8'(a * 37)) & 8'hFE;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic flash_write(logic [7:0] d);
    if (mode == 1) begin
      pcnt[la]++;
      if (pcnt[la] >= need[la]) mem[la] = mem[la] & d;
      mode = 2;
      last_kind = 1;
    end else begin
      last_kind = 0;
      case (d)
        8'h40: mode = 1;
        8'hC0: begin mode = 3; last_kind = 2; end
        8'h00: mode = 0;
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      if (we_p && !we_n) begin
        chk(!ce_n && hv_en && dq_oe, "R3 ce/hv/drive at write", {ce_n, hv_en, dq_oe}, 3'b011);
        la = addr_o;
        if (last_kind == 1) chk(hi_cnt == PC + 2, "R5 program delay", hi_cnt, PC + 2);
        low_w = 0;
      end
      if (!we_n) low_w++;
      if (!we_p && we_n) begin
        chk(low_w == WC, "R3 write-enable width", low_w, WC);
        flash_write(dq_o);
      end
      if (oe_p && !oe_n) begin
        if (last_kind == 2) chk(hi_cnt == VC + 1, "R6 verify settle", hi_cnt, VC + 1);
        rd_w = 0;
      end
      if (!oe_n) rd_w++;
      if (!oe_p && oe_n) chk(rd_w == RDC, "R6 read width", rd_w, RDC);
      if (!hv_p && hv_en) begin hv_cnt = 0; first_ce = 1; end
      if (hv_en && !ce_n && first_ce) begin
        chk(hv_cnt >= RC + 1, "R2 ramp before first bus cycle", hv_cnt, RC + 1);
        chk(addr_o == 0, "R2 first address", addr_o, 0);
        first_ce = 0;
      end
      if (hv_en) hv_cnt++;
      if (hv_p && !hv_en) begin lo_cnt = 0; dropped = 1; end
      if (done) begin
        if (dropped) chk(lo_cnt == RC, "R8 ramp down before done", lo_cnt, RC);
        dropped = 0;
        done_cnt++;
      end
      if (!hv_en) lo_cnt++;
      if (!we_p && we_n) hi_cnt = 1; else if (we_n) hi_cnt++;
      if (src_req && src_valid) begin took = 1; hs_cnt++; end
    end
    we_p = we_n; oe_p = oe_n; hv_p = hv_en;
  end

  always @(negedge clk) begin
    if (took) begin took = 0; src_valid = 0; widx++; wcnt = 0; end
    if (!src_valid) begin
      if (wcnt >= dly) begin src_valid = 1; src_data = pat(seed, widx); end
      else wcnt++;
    end
  end

  task automatic run_row(int cnt, int sd, int nd, int pos, int hn, int dl,
                         int epass, int efa, bit poke);
    int d0, perr, merr, ehs;
    @(posedge clk); #1;
    for (int a = 0; a < DEPTH; a++) begin
      mem[a] = 8'hFF; pcnt[a] = 0; need[a] = (a == pos) ? hn : nd;
    end
    seed = 8'(sd); dly = dl; widx = 0; wcnt = 0; src_valid = 0; took = 0;
    hs_cnt = 0; mode = 0; last_kind = 0;
    d0 = done_cnt;
    @(negedge clk); byte_count = (AW+1)'(cnt); start = 1;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(busy, "R11 busy mid run", busy, 1);
      byte_count = 2; start = 1;
      @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    chk(pass == epass[0], "R8 pass flag", pass, epass);
    chk(fail == !epass[0], "R9 fail flag", fail, !epass[0]);
    if (epass == 0) chk(fail_addr == AW'(efa), "R9 failing address", fail_addr, efa);
    chk(!hv_en, "R8 hv off at done", hv_en, 0);
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R11 single done pulse", done_cnt, d0 + 1);
    chk(!done && !busy, "R8 back to idle", {done, busy}, 0);
    chk(mode == 0, "R8 read command restored", mode, 0);
    perr = 0; merr = 0;
    for (int a = 0; a < DEPTH; a++) begin
      int ep;
      logic [7:0] em;
      if (a < cnt && (epass != 0 || a < efa)) ep = need[a];
      else if (epass == 0 && a == efa) ep = NP;
      else ep = 0;
      em = (ep > 0 && ep >= need[a]) ? pat(8'(sd), a) : 8'hFF;
      if (pcnt[a] != ep) perr++;
      if (mem[a] != em) merr++;
    end
    chk(perr == 0, "R7 pulses per byte", perr, 0);
    chk(merr == 0, "R4 programmed contents", merr, 0);
    ehs = (epass != 0) ? cnt : efa + 1;
    chk(hs_cnt == ehs, "R4 one fetch per byte", hs_cnt, ehs);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n && !hv_en && !dq_oe, "R1 bus idle in reset",
        {ce_n, oe_n, we_n, hv_en, dq_oe}, 5'b11100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !src_req && ce_n && !hv_en, "R1 idle after reset",
        {busy, done, src_req, ce_n, hv_en}, 5'b00010);

    for (int r = 0; r < NROW; r++)
      run_row(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4],
              TBL[r][5], TBL[r][6], TBL[r][7], 1'b0);

    // R10: zero count
    @(negedge clk); byte_count = '0; start = 1;
    @(negedge clk); start = 0;
    chk(done && pass && !fail, "R10 zero count result", {done, pass, fail}, 3'b110);
    chk(!hv_en && ce_n && we_n, "R10 no bus activity", {hv_en, ce_n, we_n}, 3'b011);
    @(negedge clk);
    chk(!busy && !hv_en, "R10 idle afterwards", {busy, hv_en}, 0);

    // R11: start while busy is ignored
    run_row(5, 'h3C, 2, 9, 1, 1, 1, 0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule